// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit computes a 32-bit memory address from up to three terms: a base register value, an index register value multiplied by a power-of-two scale, and a signed displacement. Each term is independently optional. A caller can therefore form any of these addressing shapes: displacement alone, base alone, base plus displacement, scaled index plus displacement, or all three together. The base and index values arrive already read from the register file. Any general register may feed the base.

The displacement is carried on a full-width bus, with a size code that picks how many of its low bits are meaningful. Narrow displacements are sign-extended before they are added. The scale is applied as a left shift of the index. The sum wraps modulo 2^32. It is captured in a register, and a valid flag marks the registered result one cycle after the request.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no request made, `out_valid` is 0 and `out_addr` is 0.
- R2: A request accepted with `in_valid`=1 produces `out_addr` = base term + scaled index term + displacement term. The result appears one clock after the request.
- R3: When `base_vld`=0 the base term is zero, whatever value `base_val` carries.
- R4: When `idx_vld`=0 the index term is zero, whatever value `idx_val` or `scale_code` carries.
- R5: `scale_code` multiplies the index by a power of two: 0 gives ×1, 1 gives ×2, 2 gives ×4, 3 gives ×8. Index bits shifted above bit 31 are lost.
- R6: `disp_sz` selects the displacement term. 0 means no displacement, and `disp_val` is ignored. 1 means bits 7:0 of `disp_val`, sign-extended. 2 means bits 15:0, sign-extended. 3 means all 32 bits. Bits above the selected width have no effect.
- R7: The addition wraps modulo 2^32. No carry or overflow indication exists.
- R8: `out_valid` equals the value `in_valid` had one cycle earlier. Every request yields exactly one result, and the results come out in request order.
- R9: In a cycle with `in_valid`=0, `out_addr` keeps its previous value on the next clock, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| base_vld | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| idx_vld | input | 1 | Index term present |
| idx_val | input | 32 | Index register value |
| scale_code | input | 2 | Index scale, as a power-of-two exponent |
| disp_sz | input | 2 | Displacement size code |
| disp_val | input | 32 | Displacement bits |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 32 | Registered effective address |

## Verification
Two functions of this block can act on the same request:

- sign extension of a short negative displacement, and
- modulo-2^32 wraparound of the sum.

Vectors such as a base of 0x10 with an 8-bit displacement of 0xF0 produce both at once. So does an index scaled by 8 that carries out of bit 31, combined with a negative 16-bit displacement. The scoreboard judges each of these against its own wide-integer model, truncated to 32 bits. A second coincidence is also provoked: a new request arriving in the same cycle that the previous result is presented. Back-to-back requests are mixed with idle gaps, and during the gaps the unused fields carry junk values.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int ADDR_W  = 32;
  localparam int SCALE_W = 2;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_B8   = 2'd1,
    DSZ_B16  = 2'd2,
    DSZ_FULL = 2'd3
  } disp_sz_e;
endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext #(
  parameter int AW = eag_pkg::ADDR_W
) (
  input  logic [1:0]    disp_sz,
  input  logic [AW-1:0] disp_val,
  output logic [AW-1:0] disp_term
);
  import eag_pkg::*;

  function automatic logic [AW-1:0] sext8(input logic [AW-1:0] v);
    return {{(AW-8){v[7]}}, v[7:0]};
  endfunction

  function automatic logic [AW-1:0] sext16(input logic [AW-1:0] v);
    return {{(AW-16){v[15]}}, v[15:0]};
  endfunction

  always_comb begin
    unique case (disp_sz_e'(disp_sz))
      DSZ_B8:   disp_term = sext8(disp_val);
      DSZ_B16:  disp_term = sext16(disp_val);
      DSZ_FULL: disp_term = disp_val;
      default:  disp_term = '0;
    endcase
  end
endmodule

// File: rtl/eag_idx_scale.sv
module eag_idx_scale #(
  parameter int AW  = eag_pkg::ADDR_W,
  parameter int SCW = eag_pkg::SCALE_W
) (
  input  logic           idx_vld,
  input  logic [AW-1:0]  idx_val,
  input  logic [SCW-1:0] scale_code,
  output logic [AW-1:0]  idx_term
);
  localparam int NSC = 1 << SCW;

  logic [AW-1:0] shifted [NSC];

  genvar g;
  generate
    for (g = 0; g < NSC; g++) begin : g_shift
      assign shifted[g] = idx_val << g;
    end
  endgenerate

  assign idx_term = idx_vld ? shifted[scale_code] : '0;
endmodule

// File: rtl/eag_sum3.sv
module eag_sum3 #(
  parameter int AW = eag_pkg::ADDR_W
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] c,
  output logic [AW-1:0] sum
);
  function automatic logic [AW-1:0] wrap_add3(input logic [AW-1:0] x,
                                              input logic [AW-1:0] y,
                                              input logic [AW-1:0] z);
    logic [AW-1:0] t;
    t = x + y;
    return t + z;
  endfunction

  assign sum = wrap_add3(a, b, c);
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int AW  = eag_pkg::ADDR_W,
  parameter int SCW = eag_pkg::SCALE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           base_vld,
  input  logic [AW-1:0]  base_val,
  input  logic           idx_vld,
  input  logic [AW-1:0]  idx_val,
  input  logic [SCW-1:0] scale_code,
  input  logic [1:0]     disp_sz,
  input  logic [AW-1:0]  disp_val,
  output logic           out_valid,
  output logic [AW-1:0]  out_addr
);
  logic [AW-1:0] base_term;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] disp_term;
  logic [AW-1:0] sum_next;

  assign base_term = base_vld ? base_val : '0;

  eag_idx_scale #(.AW(AW), .SCW(SCW)) u_scale (
    .idx_vld   (idx_vld),
    .idx_val   (idx_val),
    .scale_code(scale_code),
    .idx_term  (idx_term)
  );

  eag_disp_ext #(.AW(AW)) u_disp (
    .disp_sz  (disp_sz),
    .disp_val (disp_val),
    .disp_term(disp_term)
  );

  eag_sum3 #(.AW(AW)) u_sum (
    .a  (base_term),
    .b  (idx_term),
    .c  (disp_term),
    .sum(sum_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= sum_next;
    end
  end
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int AW  = 32,
  parameter int SCW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           base_vld,
  input logic           idx_vld,
  input logic [SCW-1:0] scale_code,
  input logic [1:0]     disp_sz,
  input logic [AW-1:0]  disp_val,
  input logic [AW-1:0]  disp_term,
  input logic [AW-1:0]  sum_next,
  input logic           out_valid,
  input logic [AW-1:0]  out_addr
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!out_valid && out_addr == '0);
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr == $past(sum_next));

  p_no_terms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !base_vld && !idx_vld && disp_sz == 2'd0 |=> out_addr == '0);

  p_scale8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !base_vld && idx_vld && scale_code == 2'd3 && disp_sz == 2'd0
    |=> out_addr[2:0] == 3'd0);

  p_sext8_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_sz == 2'd1 |-> disp_term[AW-1:8] == {(AW-8){disp_val[7]}}
                        && disp_term[7:0] == disp_val[7:0]);

  p_sext16_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_sz == 2'd2 |-> disp_term[AW-1:16] == {(AW-16){disp_val[15]}});

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_addr));
endmodule

bind eff_addr_gen eag_checker #(.AW(AW), .SCW(SCW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .base_vld  (base_vld),
  .idx_vld   (idx_vld),
  .scale_code(scale_code),
  .disp_sz   (disp_sz),
  .disp_val  (disp_val),
  .disp_term (disp_term),
  .sum_next  (sum_next),
  .out_valid (out_valid),
  .out_addr  (out_addr)
);

// File: tb/eff_addr_gen_tb_top.sv
module eff_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        base_vld = 1'b0;
  logic [31:0] base_val = '0;
  logic        idx_vld = 1'b0;
  logic [31:0] idx_val = '0;
  logic [1:0]  scale_code = '0;
  logic [1:0]  disp_sz = '0;
  logic [31:0] disp_val = '0;
  logic        out_valid;
  logic [31:0] out_addr;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_addr = '0;
  bit          running = 1'b0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  eff_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .base_vld(base_vld), .base_val(base_val),
    .idx_vld(idx_vld), .idx_val(idx_val), .scale_code(scale_code),
    .disp_sz(disp_sz), .disp_val(disp_val),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [31:0] ref_addr(bit bv, logic [31:0] b, bit iv,
                                           logic [31:0] i, logic [1:0] sc,
                                           logic [1:0] ds, logic [31:0] d);
    longint signed acc;
    logic signed [7:0]  d8;
    logic signed [15:0] d16;
    acc = 0;
    if (bv) acc += longint'(b);
    if (iv) acc += longint'(i) * (longint'(1) << sc);
    d8 = d[7:0];
    d16 = d[15:0];
    case (ds)
      2'd1: acc += longint'(d8);
      2'd2: acc += longint'(d16);
      2'd3: acc += longint'(d);
      default: ;
    endcase
    return acc[31:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apply(bit bv, logic [31:0] b, bit iv, logic [31:0] i,
                       logic [1:0] sc, logic [1:0] ds, logic [31:0] d, string tag);
    @(negedge clk);
    in_valid = 1'b1; base_vld = bv; base_val = b; idx_vld = iv; idx_val = i;
    scale_code = sc; disp_sz = ds; disp_val = d;
    exp_q.push_back(ref_addr(bv, b, iv, i, sc, ds, d));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      base_vld = $urandom_range(0, 1); base_val = $urandom;
      idx_vld = $urandom_range(0, 1); idx_val = $urandom;
      scale_code = 2'($urandom); disp_sz = 2'($urandom); disp_val = $urandom;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected out_valid", out_addr, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_addr === e, t, out_addr, e);
          last_addr = e;
        end
      end else begin
        check(out_addr === last_addr, "R9 hold while idle", out_addr, last_addr);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_addr === 32'h0, "R1 in reset", out_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_addr === 32'h0, "R1 after reset", out_addr, 32'h0);
    running = 1'b1;

    apply(0, 32'hDEAD0000, 0, 32'h5, 2'd2, 2'd3, 32'h00001234, "R2 R6 disp only");
    apply(1, 32'h00400000, 0, 32'hFFFF, 2'd3, 2'd0, 32'hFFFFFFFF, "R3 R6 base only, disp ignored");
    apply(1, 32'h00001000, 0, 32'h0, 2'd0, 2'd1, 32'hABCDEF10, "R2 R6 base+disp8 positive");
    idle(2);
    apply(0, 32'h12345678, 1, 32'h00000010, 2'd0, 2'd2, 32'h00000100, "R3 R5 index x1 + disp16");
    apply(0, 32'h0, 1, 32'h00000010, 2'd1, 2'd0, 32'h0, "R5 index x2");
    apply(0, 32'h0, 1, 32'h00000010, 2'd2, 2'd0, 32'h0, "R5 index x4");
    apply(0, 32'h0, 1, 32'h00000010, 2'd3, 2'd0, 32'h0, "R5 index x8");
    apply(1, 32'h00800000, 1, 32'h00000003, 2'd2, 2'd3, 32'h00000020, "R2 all three terms");
    apply(1, 32'h00000010, 0, 32'h0, 2'd0, 2'd1, 32'h000000F0, "R6 R7 disp8 negative wraps to zero");
    apply(1, 32'h00002000, 0, 32'h0, 2'd0, 2'd2, 32'h1234FFFE, "R6 disp16 negative");
    apply(0, 32'h0, 1, 32'hF0000001, 2'd3, 2'd2, 32'h00008000, "R5 R7 shifted-out bits + neg disp16");
    apply(1, 32'hFFFFFFF0, 1, 32'h00000004, 2'd2, 2'd0, 32'h0, "R7 wrap of base+index");
    apply(1, 32'h77777777, 0, 32'h99999999, 2'd3, 2'd0, 32'h55555555, "R4 index ignored when absent");
    apply(0, 32'hFFFFFFFF, 0, 32'hFFFFFFFF, 2'd3, 2'd0, 32'hFFFFFFFF, "R3 R4 R6 no terms gives zero");
    idle(3);
    for (int n = 0; n < 200; n++) begin
      apply($urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom,
            2'($urandom), 2'($urandom), $urandom, "R2 random mix");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(exp_q.size() == 0, "R8 every request answered", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule